// File: doc/BRIEF.md
# IQ Sample Frame Packer

This block gathers time-aligned samples from two IQ streams and packs them into fixed-length frames for a serial link to a converter board. Each frame carries eight consecutive sample steps. Every step holds a 14-bit in-phase value and a 14-bit quadrature value for each of the two streams. The frame opens with a constant marker word, so the receiver can find the frame boundary. The next word carries one register-access command for the far side, and a CRC-16 word closes the frame.

Samples enter through one valid/ready port that carries both streams at once. A command word enters through a separate valid/ready port. It is taken at the moment the eighth sample step is accepted. If no command is pending at that moment, a no-operation code goes in its place. The frame leaves as a stream of 16-bit words under valid/ready handshaking toward a serializer. While a frame is being sent, the sample input is stalled, so samples are held back and never dropped.

Top module: `iq_frame_packer`

## Requirements
- R1: During and right after reset, out_valid, out_last and meta_ready are 0 and in_ready is 1.
- R2: in_ready is 1 while the block is collecting samples and 0 from the cycle after the eighth sample step is accepted until the frame has been fully sent.
- R3: A frame has 35 words, and word 0 is the marker 16'hE15A.
- R4: A command pending on meta_valid when the eighth step is accepted is acknowledged by meta_ready in that same cycle, and it appears as word 1 of the frame.
- R5: With meta_valid low at the eighth acceptance, word 1 is the no-operation code 16'h0000.
- R6: Words 2 to 33 hold the samples in time order. Each step contributes four words: stream 0 I, stream 0 Q, stream 1 I, stream 1 Q. Each word has its 14-bit value in bits 13:0 and zeros in bits 15:14.
- R7: Word 34 is a CRC-16 over words 1 to 33. It uses polynomial 0x1021 and initial value 0xFFFF, processes each word most significant bit first, and applies no reflection and no final XOR.
- R8: out_last is 1 exactly while word 34 is presented.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_valid stay unchanged into the next cycle.
- R10: No frame starts before eight sample steps have been accepted, however long the input pauses.
- R11: The cycle after the final word is taken, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample step is offered |
| in_ready | output | 1 | A sample step can be accepted |
| s0_i | input | 14 | Stream 0 in-phase sample |
| s0_q | input | 14 | Stream 0 quadrature sample |
| s1_i | input | 14 | Stream 1 in-phase sample |
| s1_q | input | 14 | Stream 1 quadrature sample |
| meta_valid | input | 1 | A register-access command is pending |
| meta_word | input | 16 | Register-access command word |
| meta_ready | output | 1 | The command is taken into the frame being closed |
| out_valid | output | 1 | An output word is presented |
| out_ready | input | 1 | The serializer takes the word |
| out_data | output | 16 | Output frame word |
| out_last | output | 1 | The presented word is the checksum that ends the frame |

## Verification
A wrong fill count or word index shows up directly at the ports. Either the frame starts early or late relative to the eighth accepted step, or a word lands in the wrong slot, where the per-word compare catches it within that frame. Corrupted checksum state stays hidden until word 34, so it shows up only at the end of each frame. A stall that disturbs the index shows up at the next presented word, because the bench compares the held word across every stalled cycle.

// File: rtl/iq_frame_packer.sv
module iq_frame_packer #(
  parameter int          NSAMP     = 8,
  parameter int          SW        = 14,
  parameter int          WW        = 16,
  parameter logic [15:0] MARKER    = 16'hE15A,
  parameter logic [15:0] NOP_CODE  = 16'h0000,
  parameter logic [15:0] CRC_POLY  = 16'h1021,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] s0_i,
  input  logic [SW-1:0] s0_q,
  input  logic [SW-1:0] s1_i,
  input  logic [SW-1:0] s1_q,
  input  logic          meta_valid,
  input  logic [WW-1:0] meta_word,
  output logic          meta_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [WW-1:0] out_data,
  output logic          out_last
);
  localparam int LANES  = 4;
  localparam int NWORDS = 2 + LANES * NSAMP + 1;
  localparam int IW     = $clog2(NWORDS);
  localparam int CW     = $clog2(NSAMP + 1);
  localparam int TW     = (NSAMP > 1) ? $clog2(NSAMP) : 1;

  logic [LANES*SW-1:0] smp_q [NSAMP];
  logic [CW-1:0]       cnt_q;
  logic                sending_q;
  logic [IW-1:0]       widx_q;
  logic [WW-1:0]       meta_q;
  logic [WW-1:0]       crc_q;
  logic [IW-1:0]       k;
  logic [WW-1:0]       smp_word;

  function automatic logic [WW-1:0] crc_step(input logic [WW-1:0] c, input logic [WW-1:0] w);
    logic [WW-1:0] r;
    r = c;
    for (int b = WW - 1; b >= 0; b--) begin
      if (r[WW-1] ^ w[b]) r = {r[WW-2:0], 1'b0} ^ WW'(CRC_POLY);
      else                r = {r[WW-2:0], 1'b0};
    end
    return r;
  endfunction

  wire take      = in_valid && in_ready;
  wire fill_done = take && (cnt_q == CW'(NSAMP - 1));
  wire fire      = out_valid && out_ready;

  assign in_ready   = !sending_q;
  assign meta_ready = fill_done && meta_valid;
  assign out_valid  = sending_q;
  assign out_last   = sending_q && (widx_q == IW'(NWORDS - 1));

  assign k        = widx_q - IW'(2);
  assign smp_word = WW'(smp_q[k[TW+1:2]][k[1:0]*SW +: SW]);

  always_comb begin
    if (widx_q == '0)                     out_data = WW'(MARKER);
    else if (widx_q == IW'(1))            out_data = meta_q;
    else if (widx_q == IW'(NWORDS - 1))   out_data = crc_q;
    else                                  out_data = smp_word;
  end

  always_ff @(posedge clk) begin
    if (take) smp_q[cnt_q[TW-1:0]] <= {s1_q, s1_i, s0_q, s0_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sending_q <= 1'b0;
      widx_q    <= '0;
      meta_q    <= WW'(NOP_CODE);
      crc_q     <= WW'(CRC_INIT);
    end else begin
      if (fill_done) begin
        cnt_q     <= '0;
        sending_q <= 1'b1;
        widx_q    <= '0;
        crc_q     <= WW'(CRC_INIT);
        meta_q    <= meta_valid ? meta_word : WW'(NOP_CODE);
      end else if (take) begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (fire) begin
        if (out_last) sending_q <= 1'b0;
        else          widx_q    <= widx_q + IW'(1);
        if (widx_q != '0 && !out_last) crc_q <= crc_step(crc_q, out_data);
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_marker_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_data == WW'(MARKER));

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !out_valid);

  p_meta_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meta_ready |=> out_valid);

  p_full_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: tb/test_iq_frame_packer.sv
module test_iq_frame_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, meta_valid = 1'b0, out_ready = 1'b0;
  logic [13:0] s0_i = '0, s0_q = '0, s1_i = '0, s1_q = '0;
  logic [15:0] meta_word = '0;
  logic in_ready, meta_ready, out_valid, out_last;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_w [35];

  always #5 clk = ~clk;

  iq_frame_packer i_iq_frame_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .s0_i(s0_i), .s0_q(s0_q), .s1_i(s1_i), .s1_q(s1_q),
    .meta_valid(meta_valid), .meta_word(meta_word), .meta_ready(meta_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  // [33:18] seed, [17] command pending, [16:1] command, [0] stall output
  localparam logic [33:0] VEC [4] = '{
    {16'h0123, 1'b1, 16'hC0DE, 1'b0},
    {16'h3FFF, 1'b0, 16'h0000, 1'b1},
    {16'h0000, 1'b1, 16'h8001, 1'b1},
    {16'h2A55, 1'b0, 16'hFFFF, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] smp(input logic [15:0] seed, input int t, input int lane);
    logic [15:0] v;
    v = seed + 16'(t) * 16'h0A31 + 16'(lane) * 16'h1357;
    return v[13:0];
  endfunction

  task automatic build(input logic [15:0] seed, input logic men, input logic [15:0] cmd);
    logic [15:0] c;
    exp_w[0] = 16'hE15A;
    exp_w[1] = men ? cmd : 16'h0000;
    for (int t = 0; t < 8; t++)
      for (int l = 0; l < 4; l++) exp_w[2 + 4*t + l] = {2'b00, smp(seed, t, l)};
    c = 16'hFFFF;
    for (int w = 1; w < 34; w++)
      for (int b = 15; b >= 0; b--) begin
        logic top;
        top = c[15];
        c = c << 1;
        if (top != exp_w[w][b]) c = c ^ 16'h1021;
      end
    exp_w[34] = c;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 0);
    chk("R1 in_ready in reset", 32'(in_ready), 1);
    chk("R1 meta_ready in reset", 32'(meta_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_last after reset", 32'(out_last), 0);

    for (int r = 0; r < 4; r++) begin
      logic [15:0] seed, cmd;
      logic men, stall, prev_stall;
      logic [15:0] prev_data;
      int idx, cyc;
      seed = VEC[r][33:18]; men = VEC[r][17]; cmd = VEC[r][16:1]; stall = VEC[r][0];
      build(seed, men, cmd);
      for (int t = 0; t < 8; t++) begin
        in_valid = 1'b1;
        s0_i = smp(seed, t, 0); s0_q = smp(seed, t, 1);
        s1_i = smp(seed, t, 2); s1_q = smp(seed, t, 3);
        meta_valid = (t == 7) ? men : (t == 3);
        meta_word = (t == 7) ? cmd : 16'hBEEF;
        #1;
        chk("R2 in_ready while filling", 32'(in_ready), 1);
        chk("R4 meta_ready only on eighth step", 32'(meta_ready), (t == 7) ? 32'(men) : 0);
        @(negedge clk);
        if (t == 6) begin
          in_valid = 1'b0; meta_valid = 1'b0;
          repeat (4) @(negedge clk);
          chk("R10 no frame after seven steps", 32'(out_valid), 0);
        end
      end
      in_valid = 1'b1; meta_valid = 1'b0;
      s0_i = 14'h1111;
      #1;
      chk("R2 in_ready low while sending", 32'(in_ready), 0);
      chk("R2 frame started", 32'(out_valid), 1);
      idx = 0; cyc = 0; prev_stall = 1'b0; prev_data = '0;
      while (idx < 35) begin
        logic rdy;
        rdy = !(stall && (cyc % 3 == 1));
        out_ready = rdy;
        #1;
        if (prev_stall) chk("R9 word held under stall", 32'(out_data), 32'(prev_data));
        chk("R2 frame valid", 32'(out_valid), 1);
        if (idx == 0)       chk("R3 marker word", 32'(out_data), 32'(exp_w[0]));
        else if (idx == 1)  chk(men ? "R4 command word" : "R5 no-op word", 32'(out_data), 32'(exp_w[1]));
        else if (idx == 34) chk("R7 crc word", 32'(out_data), 32'(exp_w[34]));
        else                chk("R6 sample word", 32'(out_data), 32'(exp_w[idx]));
        chk("R8 last flag", 32'(out_last), 32'(idx == 34));
        if (rdy) idx++;
        prev_stall = !rdy;
        prev_data = out_data;
        @(negedge clk);
        cyc++;
      end
      out_ready = 1'b0;
      in_valid = 1'b0;
      #1;
      chk("R11 released after last word", 32'({out_valid, in_ready}), 32'b01);
      @(negedge clk);
    end
    summary();
    $finish;
  end
endmodule